// File: doc/BRIEF.md
# SMBus Host Notify Status and Event Logic

This block sits beside the receive engine of an SMBus target port. Each time that engine finishes a valid Host Notify message, it hands over the sender's address byte and the 16-bit data word. The block copies both into holding registers and raises a sticky notify flag. While that flag is up, the block tells the engine to refuse the address byte of any further Host Notify, so the bus itself holds back new notifies until software has read the first one.

Software reaches the block through a byte-wide register port. The port offers a status register, a command register and read-only views of the held address and data. To clear the flag, software writes a one to its bit. A write takes effect at the next clock edge, and software confirms it by reading the register back.

The block also drives two combined outputs. The interrupt output follows the notify flag and the alert source, and the alert source can be masked for this output only. The wake output merges the notify flag, when wake is enabled, with the alert source and the other wake sources. The alert mask does not reach the wake output.

Top module: `smb_notify_regs`

## Requirements
- R1: After reset (`rst_n` low), the status and command registers read 00h, and `notify_nack`, `irq` and `wake` are low when `alert_sts` and `other_wake` are low.
- R2: A `notify_done` pulse sets the notify flag at the next clock edge. The flag reads back as bit 0 of offset 10h, and bits 7:1 of offset 10h always read 0.
- R3: A write to offset 10h with bit 0 equal to 1 clears the flag at the next edge. A write with bit 0 equal to 0 leaves the flag as it was.
- R4: `notify_nack` is high exactly while the notify flag is set.
- R5: A notify accepted while the flag is clear loads the held address (offset 14h) and the held data (low byte at 16h, high byte at 17h). While the flag is set, a new `notify_done` changes neither the held values nor the flag.
- R6: If `notify_done` and a clearing write to offset 10h arrive in the same cycle, the flag stays set and the new address and data are loaded.
- R7: Offset 11h holds the wake enable in bit 1 and the alert mask in bit 2. Its other bits always read 0, and offsets with no register read 00h.
- R8: `irq` equals the notify flag OR (`alert_sts` AND NOT the alert mask).
- R9: `wake` equals `other_wake` OR `alert_sts` OR (the notify flag AND the wake enable). The alert mask has no effect on `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Resume-well reset, asynchronous, active low |
| reg_addr | input | 8 | Register offset for reads and writes |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| notify_done | input | 1 | Receive engine finished a valid Host Notify |
| notify_addr | input | 8 | Address byte of the finished notify |
| notify_data | input | 16 | Data word of the finished notify |
| notify_nack | output | 1 | Tells the engine to refuse the next notify address byte |
| alert_sts | input | 1 | Alert status from the alert source |
| other_wake | input | 1 | OR of the other SMBus wake sources |
| irq | output | 1 | Combined interrupt request |
| wake | output | 1 | Combined SMBus wake status |

## Verification
Two functions can fall in the same clock edge: a completed notify arriving from the engine and a software write of one to the flag. The bench provokes this with a directed case that presents both in one cycle, after a notify is already pending. The random phase also overlaps them often, because notifies and writes to offset 10h are both frequent there. The outcome is judged by reading back the flag and all three held bytes: the flag must still be set and the bytes must hold the values of the new notify.

// File: rtl/smb_notify_pkg.sv
package smb_notify_pkg;

  localparam int unsigned REG_BYTE_W = 8;

  // register offsets
  localparam logic [7:0] OFS_STS    = 8'h10;
  localparam logic [7:0] OFS_CMD    = 8'h11;
  localparam logic [7:0] OFS_HADDR  = 8'h14;
  localparam logic [7:0] OFS_HDATA0 = 8'h16;

  // bit positions
  localparam int unsigned STS_FLAG_BIT = 0;
  localparam int unsigned CMD_WKEN_BIT = 1;
  localparam int unsigned CMD_AMSK_BIT = 2;

  typedef struct packed {
    logic alert_mask;
    logic wake_en;
  } cmd_t;

endpackage

// File: rtl/notify_status.sv
module notify_status
  import smb_notify_pkg::*;
#(
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_req,
  input  logic              evt_valid,
  input  logic [SRC_W-1:0]  evt_src,
  input  logic [DATA_W-1:0] evt_data,
  output logic              flag_q,
  output logic [SRC_W-1:0]  src_q,
  output logic [DATA_W-1:0] data_q
);

  logic              accept;
  logic              flag_d;
  logic [SRC_W-1:0]  src_d;
  logic [DATA_W-1:0] data_d;

  // a new event is taken when nothing is pending, or when the pending one
  // is being released in this very cycle
  always_comb begin
    accept = evt_valid & (~flag_q | clr_req);
    flag_d = flag_q;
    src_d  = src_q;
    data_d = data_q;
    if (accept) begin
      flag_d = 1'b1;
      src_d  = evt_src;
      data_d = evt_data;
    end else if (clr_req) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      data_q <= '0;
    end else if (accept) begin
      src_q  <= src_d;
      data_q <= data_d;
    end
  end

  // R2
  // event_sets_flag_chk
  event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> flag_q);

  // R3
  // clear_drops_flag_chk
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !evt_valid) |=> !flag_q);

  // R5
  // held_values_frozen_chk
  held_values_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> ($stable(src_q) && $stable(data_q) && flag_q));

  // R6
  // collision_keeps_new_chk
  collision_keeps_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && evt_valid) |=> (flag_q && src_q == $past(evt_src)
                                && data_q == $past(evt_data)));

endmodule

// File: rtl/notify_cmd_reg.sv
module notify_cmd_reg
  import smb_notify_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_BYTE_W-1:0] wr_data,
  output cmd_t                  cmd_q
);

  cmd_t cmd_d;

  always_comb begin
    cmd_d = cmd_q;
    if (wr_en) begin
      cmd_d.wake_en    = wr_data[CMD_WKEN_BIT];
      cmd_d.alert_mask = wr_data[CMD_AMSK_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (wr_en) begin
      cmd_q <= cmd_d;
    end
  end

  // R7
  // cmd_hold_chk
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cmd_q));

endmodule

// File: rtl/notify_event_comb.sv
module notify_event_comb
  import smb_notify_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  input  cmd_t cmd,
  input  logic alert_in,
  input  logic other_wake_in,
  output logic irq_o,
  output logic wake_o
);

  logic alert_irq;
  logic notify_wake;

  always_comb begin
    alert_irq   = alert_in & ~cmd.alert_mask;
    notify_wake = flag & cmd.wake_en;
    irq_o       = flag | alert_irq;
    wake_o      = other_wake_in | alert_in | notify_wake;
  end

  // R8
  // masked_alert_quiet_chk
  masked_alert_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.alert_mask && !flag) |-> !irq_o);

  // R9
  // alert_wakes_despite_mask_chk
  alert_wakes_despite_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_in |-> wake_o);

endmodule

// File: rtl/smb_notify_regs.sv
module smb_notify_regs
  import smb_notify_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_wr,
  input  logic [REG_BYTE_W-1:0] reg_wdata,
  output logic [REG_BYTE_W-1:0] reg_rdata,
  input  logic                  notify_done,
  input  logic [SRC_W-1:0]      notify_addr,
  input  logic [DATA_W-1:0]     notify_data,
  output logic                  notify_nack,
  input  logic                  alert_sts,
  input  logic                  other_wake,
  output logic                  irq,
  output logic                  wake
);

  localparam int unsigned DATA_BYTES = (DATA_W + REG_BYTE_W - 1) / REG_BYTE_W;
  localparam int unsigned DATA_PAD_W = DATA_BYTES * REG_BYTE_W;

  logic              sel_sts;
  logic              sel_cmd;
  logic              clr_req;
  logic              flag_q;
  logic [SRC_W-1:0]  src_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_PAD_W-1:0] data_pad;
  cmd_t              cmd_q;

  assign sel_sts = (reg_addr == ADDR_W'(OFS_STS));
  assign sel_cmd = (reg_addr == ADDR_W'(OFS_CMD));
  assign clr_req = reg_wr & sel_sts & reg_wdata[STS_FLAG_BIT];

  notify_status #(
    .SRC_W  (SRC_W),
    .DATA_W (DATA_W)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_req   (clr_req),
    .evt_valid (notify_done),
    .evt_src   (notify_addr),
    .evt_data  (notify_data),
    .flag_q    (flag_q),
    .src_q     (src_q),
    .data_q    (data_q)
  );

  notify_cmd_reg u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr & sel_cmd),
    .wr_data (reg_wdata),
    .cmd_q   (cmd_q)
  );

  notify_event_comb u_evt (
    .clk           (clk),
    .rst_n         (rst_n),
    .flag          (flag_q),
    .cmd           (cmd_q),
    .alert_in      (alert_sts),
    .other_wake_in (other_wake),
    .irq_o         (irq),
    .wake_o        (wake)
  );

  assign notify_nack = flag_q;

  assign data_pad = DATA_PAD_W'(data_q);

  // read mux; data bytes sit at consecutive offsets from the low byte
  always_comb begin
    reg_rdata = '0;
    if (sel_sts) begin
      reg_rdata[STS_FLAG_BIT] = flag_q;
    end else if (sel_cmd) begin
      reg_rdata[CMD_WKEN_BIT] = cmd_q.wake_en;
      reg_rdata[CMD_AMSK_BIT] = cmd_q.alert_mask;
    end else if (reg_addr == ADDR_W'(OFS_HADDR)) begin
      reg_rdata = REG_BYTE_W'(src_q);
    end else begin
      for (int i = 0; i < DATA_BYTES; i++) begin
        if (reg_addr == ADDR_W'(OFS_HDATA0 + i))
          reg_rdata = data_pad[i*REG_BYTE_W +: REG_BYTE_W];
      end
    end
  end

  // R4
  // nack_follows_accept_chk
  nack_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (notify_done && !notify_nack) |=> notify_nack);

  // R2
  // sts_reserved_zero_chk
  sts_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_sts |-> (reg_rdata[7:1] == 7'd0));

endmodule

// File: tb/test_smb_notify_regs.sv
module test_smb_notify_regs;

  logic        clk;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        notify_done;
  logic [7:0]  notify_addr;
  logic [15:0] notify_data;
  logic        notify_nack;
  logic        alert_sts;
  logic        other_wake;
  logic        irq;
  logic        wake;

  int n_chk;
  int n_fail;
  bit done;

  // bench model
  bit        m_flag;
  bit        m_wen;
  bit        m_msk;
  bit [7:0]  m_src;
  bit [15:0] m_data;

  smb_notify_regs i_smb_notify_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .notify_done(notify_done),
    .notify_addr(notify_addr), .notify_data(notify_data),
    .notify_nack(notify_nack), .alert_sts(alert_sts), .other_wake(other_wake),
    .irq(irq), .wake(wake)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit [7:0] exp_rd(input bit [7:0] a);
    case (a)
      8'h10:   return {7'd0, m_flag};
      8'h11:   return {5'd0, m_msk, m_wen, 1'b0};
      8'h14:   return m_src;
      8'h16:   return m_data[7:0];
      8'h17:   return m_data[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit exp_irq();
    return m_flag | (alert_sts & ~m_msk);
  endfunction

  function automatic bit exp_wake();
    return other_wake | alert_sts | (m_flag & m_wen);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " R4 nack"}, notify_nack, m_flag);
    chk({req, " R8 irq"}, irq, exp_irq());
    chk({req, " R9 wake"}, wake, exp_wake());
    chk({req, " R7 rdata"}, reg_rdata, exp_rd(reg_addr));
  endtask

  // drive, check before the edge, advance model across the edge
  task automatic step(input bit wr, input bit [7:0] a, input bit [7:0] wd,
                      input bit nd, input bit [7:0] ns, input bit [15:0] ndat,
                      input bit al, input bit ow, input string req);
    bit clr;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    notify_done = nd; notify_addr = ns; notify_data = ndat;
    alert_sts = al; other_wake = ow;
    #1;
    check_all(req);
    @(posedge clk);
    clr = wr && a == 8'h10 && wd[0];
    if (nd && (!m_flag || clr)) begin
      m_flag = 1; m_src = ns; m_data = ndat;
    end else if (clr) m_flag = 0;
    if (wr && a == 8'h11) begin
      m_wen = wd[1]; m_msk = wd[2];
    end
    @(negedge clk);
  endtask

  task automatic rd(input bit [7:0] a, input string req);
    step(0, a, 8'h00, 0, 8'h00, 16'h0000, 0, 0, req);
  endtask

  function automatic bit [7:0] pick_addr();
    case ($urandom_range(0, 6))
      0, 1:    return 8'h10;
      2:       return 8'h11;
      3:       return 8'h14;
      4:       return 8'h16;
      5:       return 8'h17;
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; reg_wr = 0; reg_addr = 8'h10; reg_wdata = 0;
    notify_done = 0; notify_addr = 0; notify_data = 0;
    alert_sts = 0; other_wake = 0;
    m_flag = 0; m_wen = 0; m_msk = 0; m_src = 0; m_data = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    chk("R1 sts", reg_rdata, 8'h00);
    chk("R1 nack", notify_nack, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wake", wake, 0);
    reg_addr = 8'h11; #1;
    chk("R1 cmd", reg_rdata, 8'h00);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 notify sets flag, R5 latch
    step(0, 8'h10, 0, 1, 8'hA6, 16'hBEEF, 0, 0, "R2 notify");
    rd(8'h10, "R2 flag set");
    rd(8'h14, "R5 held addr");
    rd(8'h17, "R5 held data hi");
    // R5 second notify ignored while pending
    step(0, 8'h16, 0, 1, 8'h12, 16'h3456, 0, 0, "R5 blocked notify");
    rd(8'h16, "R5 data lo kept");
    rd(8'h14, "R5 addr kept");
    // R3 write 0 no effect
    step(1, 8'h10, 8'hFE, 0, 0, 0, 0, 0, "R3 write zero");
    rd(8'h10, "R3 flag still set");
    // R6 collision: clear and new notify same cycle
    step(1, 8'h10, 8'h01, 1, 8'h5C, 16'hC0DE, 0, 0, "R6 collision");
    rd(8'h10, "R6 flag kept");
    rd(8'h14, "R6 new addr");
    rd(8'h16, "R6 new data lo");
    rd(8'h17, "R6 new data hi");
    // R3 clear
    step(1, 8'h10, 8'h01, 0, 0, 0, 0, 0, "R3 clear");
    rd(8'h10, "R3 flag cleared");
    // R7/R8/R9 mask affects irq but not wake
    step(1, 8'h11, 8'hFF, 0, 0, 0, 0, 0, "R7 cmd write");
    rd(8'h11, "R7 cmd readback");
    step(0, 8'h11, 0, 0, 0, 0, 1, 0, "R8 R9 masked alert");
    step(1, 8'h11, 8'h02, 0, 0, 0, 1, 0, "R8 unmask");
    step(0, 8'h11, 0, 0, 0, 0, 1, 0, "R8 alert irq");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 2) == 0, pick_addr(), 8'($urandom()),
           $urandom_range(0, 3) == 0, 8'($urandom()), 16'($urandom()),
           $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0, "rand");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule